// File: doc/BRIEF.md
# Narrow Float Element Decoder

This block turns one byte holding a narrow floating-point matrix element into an IEEE binary32 value, ready for a single-precision accumulator. A 3-bit format code picks one of five element layouts (4 or 5 or 3 or 2 exponent bits with a matching mantissa width, plus a sign). A pair flag, legal with the 2-bit-exponent/1-bit-mantissa format, treats the byte as two unpadded 4-bit elements and produces two results at once.

An optional exponent-only block scale (8 bits, unsigned, biased by 127) multiplies the decoded element by a power of two. Every legal input lands on an exactly representable binary32 value, so the block never rounds. It saturates to infinity on overflow and produces exact subnormals on underflow. Inputs and results move through a valid/ready handshake with a single registered output stage.

Top module: `nfloat_unpack`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. A transfer happens only when `in_valid` and `in_ready` are both 1, and its result appears on the outputs with `out_valid` = 1 after that clock edge. While `out_valid` = 1 and `out_ready` = 0, both outputs hold.
- R3: Format code 0 (4 exponent bits, 3 mantissa bits, bias 7) uses sign bit 7, exponent bits 6:3 and mantissa bits 2:0. Exponent zero decodes as a subnormal. Exponent 15 with mantissa 7 gives NaN 0x7FC00000, and there is no infinity.
- R4: Format code 1 (5 exponent bits, 2 mantissa bits, bias 15) uses sign bit 7, exponent bits 6:2 and mantissa bits 1:0. Exponent 31 gives a signed infinity when the mantissa is zero and NaN 0x7FC00000 otherwise.
- R5: Format code 2 (3 exponent bits, 2 mantissa bits, bias 3) uses sign bit 5, exponent bits 4:2 and mantissa bits 1:0. Bits 7:6 have no effect, and there is no infinity or NaN.
- R6: Format code 3 (2 exponent bits, 3 mantissa bits, bias 1) uses sign bit 5, exponent bits 4:3 and mantissa bits 2:0. Bits 7:6 have no effect.
- R7: Format code 4 (2 exponent bits, 1 mantissa bit, bias 1) with `pair_mode` = 0 takes the element from bits 5:2 (sign 5, exponent 4:3, mantissa 2). Bits 7:6 and 1:0 have no effect, and `out_hi` is 0.
- R8: Format code 4 with `pair_mode` = 1 decodes bits 3:0 to `out_lo` and bits 7:4 to `out_hi`, each laid out as sign, exponent, exponent, mantissa from the top. For any other format, `pair_mode` has no effect and `out_hi` is 0.
- R9: With `scale_en` = 1, each result is the decoded value times 2^(`scale_exp` − 127). With `scale_en` = 0, no scaling is applied.
- R10: With `scale_en` = 1 and `scale_exp` = 0xFF, every produced lane is NaN 0x7FC00000.
- R11: A scaled magnitude above the binary32 range gives a signed infinity. One below the normal range gives the exact subnormal, and a zero element gives a zero that keeps its sign.
- R12: Format codes 5 to 7 give NaN 0x7FC00000 on `out_lo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input element is valid |
| in_ready | output | 1 | Block can take an input |
| in_byte | input | 8 | Byte container holding the element(s) |
| fmt_sel | input | 3 | Element format code |
| pair_mode | input | 1 | Two unpadded 4-bit elements per byte (format 4 only) |
| scale_en | input | 1 | Apply the power-of-two block scale |
| scale_exp | input | 8 | Biased scale exponent (bias 127, 0xFF = NaN) |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_lo | output | 32 | binary32 result (low/only element) |
| out_hi | output | 32 | binary32 result of the upper nibble in pair mode, else 0 |

## Verification
Every byte value is tried in each of the five formats, both with and without pair mode. This separates the bit placement, bias and special-value rules of each format, and shows that padding bits and the pair flag have no effect where they should not. A sweep of scale exponents (0, 1, 100, 127, 130, 200, 254, 255) over whole formats tells normal scaling apart from saturation to infinity, exact subnormal results and the NaN scale code. Random stalls on both sides of the handshake separate correct holding of the output register from lost or repeated results.

// File: rtl/nfu_pkg.sv
package nfu_pkg;
   typedef enum logic [2:0] {
      FMT_E4M3 = 3'd0,
      FMT_E5M2 = 3'd1,
      FMT_E3M2 = 3'd2,
      FMT_E2M3 = 3'd3,
      FMT_E2M1 = 3'd4
   } nfu_fmt_e;

   // Element fields normalized to a common shape: mantissa left-aligned to 3 bits.
   typedef struct packed {
      logic       sgn;
      logic [4:0] expf;
      logic [2:0] manf;
      logic [4:0] bias;
      logic       is_inf;
      logic       is_nan;
      logic       bad_fmt;
   } nfu_fields_t;

   localparam logic [31:0] NFU_QNAN = 32'h7FC0_0000;
endpackage

// File: rtl/nfu_split.sv
module nfu_split
   import nfu_pkg::*;
#(
   parameter int LANE   = 0,
   parameter int BYTE_W = 8,
   parameter int FMT_W  = 3
) (
   input  logic [BYTE_W-1:0] byte_i,
   input  logic [FMT_W-1:0]  fmt_i,
   input  logic              pair_i,
   output nfu_fields_t       fields_o
);
   logic [3:0] nib;

   generate
      if (BYTE_W != 8) begin : g_bad_width
         $error("nfu_split: byte container must be 8 bits");
      end
      if (LANE == 0) begin : g_low
         assign nib = pair_i ? byte_i[3:0] : byte_i[5:2];
      end else begin : g_high
         assign nib = pair_i ? byte_i[7:4] : byte_i[5:2];
      end
   endgenerate

   always_comb begin
      fields_o = '0;
      case (fmt_i)
         FMT_E4M3: begin
            fields_o.sgn    = byte_i[7];
            fields_o.expf   = {1'b0, byte_i[6:3]};
            fields_o.manf   = byte_i[2:0];
            fields_o.bias   = 5'd7;
            fields_o.is_nan = (byte_i[6:0] == 7'h7F);
         end
         FMT_E5M2: begin
            fields_o.sgn    = byte_i[7];
            fields_o.expf   = byte_i[6:2];
            fields_o.manf   = {byte_i[1:0], 1'b0};
            fields_o.bias   = 5'd15;
            fields_o.is_inf = (byte_i[6:2] == 5'h1F) && (byte_i[1:0] == 2'b00);
            fields_o.is_nan = (byte_i[6:2] == 5'h1F) && (byte_i[1:0] != 2'b00);
         end
         FMT_E3M2: begin
            fields_o.sgn  = byte_i[5];
            fields_o.expf = {2'b00, byte_i[4:2]};
            fields_o.manf = {byte_i[1:0], 1'b0};
            fields_o.bias = 5'd3;
         end
         FMT_E2M3: begin
            fields_o.sgn  = byte_i[5];
            fields_o.expf = {3'b000, byte_i[4:3]};
            fields_o.manf = byte_i[2:0];
            fields_o.bias = 5'd1;
         end
         FMT_E2M1: begin
            fields_o.sgn  = nib[3];
            fields_o.expf = {3'b000, nib[2:1]};
            fields_o.manf = {nib[0], 2'b00};
            fields_o.bias = 5'd1;
         end
         default: fields_o.bad_fmt = 1'b1;
      endcase
   end
endmodule

// File: rtl/nfu_cvt.sv
module nfu_cvt
   import nfu_pkg::*;
#(
   parameter int SCALE_W    = 8,
   parameter int SCALE_BIAS = 127,
   parameter int F32_W      = 32
) (
   input  nfu_fields_t        fields_i,
   input  logic               scale_en_i,
   input  logic [SCALE_W-1:0] scale_i,
   output logic [F32_W-1:0]   value_o
);
   localparam int SW = 12;
   localparam logic signed [SW-1:0] EMAX = SW'(127);
   localparam logic signed [SW-1:0] EMIN = -SW'(126);

   logic signed [SW-1:0] ue, adj, se, sh;
   logic [2:0]           frac;
   logic [23:0]          sig;
   logic [7:0]           ebias;

   generate
      if (F32_W != 32) begin : g_bad_out
         $error("nfu_cvt: output must be binary32");
      end
      if (SCALE_W != 8 || SCALE_BIAS != 127) begin : g_bad_scale
         $error("nfu_cvt: scale must be 8-bit with bias 127");
      end
   endgenerate

   always_comb begin
      frac = fields_i.manf;
      ue   = $signed({7'b0, fields_i.expf}) - $signed({7'b0, fields_i.bias});
      if (fields_i.expf == '0) begin
         casez (fields_i.manf)
            3'b1??: begin
               ue   = -$signed({7'b0, fields_i.bias});
               frac = {fields_i.manf[1:0], 1'b0};
            end
            3'b01?: begin
               ue   = -$signed({7'b0, fields_i.bias}) - SW'(1);
               frac = {fields_i.manf[0], 2'b00};
            end
            default: begin
               ue   = -$signed({7'b0, fields_i.bias}) - SW'(2);
               frac = 3'b000;
            end
         endcase
      end
      adj   = scale_en_i ? ($signed({4'b0, scale_i}) - SW'(SCALE_BIAS)) : '0;
      se    = ue + adj;
      sh    = EMIN - se;
      ebias = 8'(se + EMAX);
      sig   = {1'b1, frac, 20'b0};

      if (fields_i.bad_fmt || fields_i.is_nan || (scale_en_i && (&scale_i)))
         value_o = NFU_QNAN;
      else if (fields_i.is_inf)
         value_o = {fields_i.sgn, 8'hFF, 23'b0};
      else if (fields_i.expf == '0 && fields_i.manf == '0)
         value_o = {fields_i.sgn, 31'b0};
      else if (se > EMAX)
         value_o = {fields_i.sgn, 8'hFF, 23'b0};
      else if (se >= EMIN)
         value_o = {fields_i.sgn, ebias, frac, 20'b0};
      else if (sh > SW'(23))
         value_o = {fields_i.sgn, 31'b0};
      else
         value_o = {fields_i.sgn, 8'b0, 23'(sig >> 5'(sh))};
   end
endmodule

// File: rtl/nfloat_unpack.sv
module nfloat_unpack
   import nfu_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int FMT_W      = 3,
   parameter int SCALE_W    = 8,
   parameter int SCALE_BIAS = 127,
   parameter int F32_W      = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [BYTE_W-1:0]  in_byte,
   input  logic [FMT_W-1:0]   fmt_sel,
   input  logic               pair_mode,
   input  logic               scale_en,
   input  logic [SCALE_W-1:0] scale_exp,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [F32_W-1:0]   out_lo,
   output logic [F32_W-1:0]   out_hi
);
   localparam int LANES = 2;

   logic             take, pair_now, pair_q;
   logic [F32_W-1:0] lane_val [LANES];

   generate
      if (FMT_W < 3) begin : g_bad_fmt
         $error("nfloat_unpack: format code needs at least 3 bits");
      end
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         nfu_fields_t fl;
         logic [F32_W-1:0] val;
         nfu_split #(.LANE(l), .BYTE_W(BYTE_W), .FMT_W(FMT_W)) u_split (
            .byte_i(in_byte), .fmt_i(fmt_sel), .pair_i(pair_now), .fields_o(fl));
         nfu_cvt #(.SCALE_W(SCALE_W), .SCALE_BIAS(SCALE_BIAS), .F32_W(F32_W)) u_cvt (
            .fields_i(fl), .scale_en_i(scale_en), .scale_i(scale_exp), .value_o(val));
         assign lane_val[l] = val;
      end
   endgenerate

   assign pair_now = pair_mode && (fmt_sel == FMT_W'(FMT_E2M1));
   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         pair_q    <= 1'b0;
         out_lo    <= '0;
         out_hi    <= '0;
      end else if (take) begin
         out_valid <= 1'b1;
         pair_q    <= pair_now;
         out_lo    <= lane_val[0];
         out_hi    <= pair_now ? lane_val[1] : '0;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   // R2
   hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_lo) && $stable(out_hi));
   // R2
   load_on_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);
   // R8
   single_lane_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !pair_q |-> out_hi == '0);
   // R10
   nan_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && scale_en && (&scale_exp) |=> out_lo == NFU_QNAN);
   // R12
   bad_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && (fmt_sel > FMT_W'(4)) |=> out_lo == NFU_QNAN);
endmodule

// File: tb/nfloat_unpack_test.sv
`timescale 1ns/1ps
module nfloat_unpack_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_ready;
   logic [7:0]  in_byte = '0;
   logic [2:0]  fmt_sel = '0;
   logic        pair_mode = 1'b0, scale_en = 1'b0;
   logic [7:0]  scale_exp = '0;
   logic        out_valid, out_ready = 1'b0;
   logic [31:0] out_lo, out_hi;

   int checks = 0, failures = 0;
   bit        m_valid = 0;
   logic [31:0] m_lo = '0, m_hi = '0;
   string     m_tag = "R2";
   localparam logic [31:0] QNAN = 32'h7FC0_0000;

   always #2.5 clk = ~clk;

   nfloat_unpack uut (.*);

   function automatic logic [31:0] enc(int s, int sig, int e2);
      int x, sh;
      if (sig == 0) return {s[0], 31'b0};
      while (sig < (1 << 23)) begin sig = sig << 1; e2 = e2 - 1; end
      x = e2 + 23;
      if (x > 127) return {s[0], 8'hFF, 23'b0};
      if (x >= -126) return {s[0], 8'(x + 127), 23'(sig)};
      sh = -126 - x;
      if (sh > 23) return {s[0], 31'b0};
      return {s[0], 8'b0, 23'(sig >> sh)};
   endfunction

   function automatic logic [31:0] ref_val(int b, int f, bit pk, bit sen, int sc, int lane);
      int ew, mw, fld, s, e, m, bias, sig, e2;
      if (f > 4) return QNAN;
      if (sen && sc == 255) return QNAN;
      case (f)
         0: begin ew = 4; mw = 3; fld = b; end
         1: begin ew = 5; mw = 2; fld = b; end
         2: begin ew = 3; mw = 2; fld = b & 63; end
         3: begin ew = 2; mw = 3; fld = b & 63; end
         default: begin
            ew = 2; mw = 1;
            fld = (lane == 1) ? ((b >> 4) & 15) : (pk ? (b & 15) : ((b >> 2) & 15));
         end
      endcase
      s = (fld >> (ew + mw)) & 1;
      e = (fld >> mw) & ((1 << ew) - 1);
      m = fld & ((1 << mw) - 1);
      bias = (1 << (ew - 1)) - 1;
      if (f == 1 && e == 31) return (m != 0) ? QNAN : {s[0], 8'hFF, 23'b0};
      if (f == 0 && e == 15 && m == 7) return QNAN;
      if (e == 0) begin sig = m; e2 = 1 - bias - mw; end
      else begin sig = (1 << mw) | m; e2 = e - bias - mw; end
      if (sen) e2 = e2 + sc - 127;
      return enc(s, sig, e2);
   endfunction

   task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare();
      chk(out_valid == m_valid, "R2", "out_valid", 32'(out_valid), 32'(m_valid));
      if (m_valid) begin
         chk(out_lo == m_lo, m_tag, "out_lo", out_lo, m_lo);
         chk(out_hi == m_hi, m_tag, "out_hi", out_hi, m_hi);
      end
   endtask

   task automatic push(int b, int f, bit pk, bit sen, int sc, string tag);
      bit done = 0;
      while (!done) begin
         bit v, r, acc;
         @(negedge clk);
         compare();
         v = ($urandom % 5) != 0;
         r = ($urandom % 4) != 0;
         out_ready = r; in_valid = v; in_byte = 8'(b); fmt_sel = 3'(f);
         pair_mode = pk; scale_en = sen; scale_exp = 8'(sc);
         #1;
         chk(in_ready == (!m_valid || r), "R2", "in_ready", 32'(in_ready), 32'(!m_valid || r));
         acc = v && (!m_valid || r);
         if (acc) begin
            m_lo = ref_val(b, f, pk, sen, sc, 0);
            m_hi = (pk && f == 4) ? ref_val(b, f, pk, sen, sc, 1) : 32'h0;
            m_tag = tag; m_valid = 1; done = 1;
         end else if (r) m_valid = 0;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++; checks++;
      $display("FAIL watchdog R2 actual=%h expected=%h", 32'(0), 32'(1));
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int scl [8] = '{0, 1, 100, 127, 130, 200, 254, 255};
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'(0));
      chk(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'(1));
      // R3 R4 R5 R6 R7 R8: every byte in every format, both pair settings
      for (int f = 0; f < 5; f++)
         for (int pk = 0; pk < 2; pk++)
            for (int b = 0; b < 256; b++) begin
               string tg;
               if (pk == 1) tg = "R8";
               else case (f) 0: tg = "R3"; 1: tg = "R4"; 2: tg = "R5"; 3: tg = "R6"; default: tg = "R7"; endcase
               push(b, f, pk[0], 1'b0, 0, tg);
            end
      // R9 R10 R11: scale sweep
      for (int f = 0; f < 5; f++)
         for (int i = 0; i < 8; i++)
            for (int b = 0; b < 256; b += 3) begin
               string tg;
               tg = (scl[i] == 255) ? "R10" : ((scl[i] == 0 || scl[i] == 254) ? "R11" : "R9");
               push(b, f, (f == 4) && (b % 2 == 1), 1'b1, scl[i], tg);
            end
      // R12: unused format codes
      for (int f = 5; f < 8; f++)
         for (int b = 0; b < 256; b += 17) push(b, f, b[0], 1'b0, 0, "R12");
      repeat (4) begin
         @(negedge clk);
         compare();
         in_valid = 1'b0; out_ready = 1'b1; m_valid = 0;
      end
      @(negedge clk);
      compare();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule